// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller sits beside a small processor core and decides what the core does after it executes its sleep instruction. It holds one 8-bit control register. That register selects four things: whether a sleep request leads to a light sleep or a deep stop, how long to wait for the oscillator to settle on wake-up, whether the core runs from the main clock or from the subclock, and the divide ratio used in medium-speed active operation. The core pulses `sleep_req` when the instruction retires. The controller then drops `core_run` and reports the low-power state it has entered on `mode_o`.

When a wake event arrives during a light sleep, the core resumes on the next clock. When it arrives during a deep stop, the controller counts a programmable settling wait first, and only then raises `core_run` again. The oscillators and the interrupt logic that produces `wake_evt` are outside this block.

The interface carries no data stream. Every pin is a plain level or a one-cycle pulse, so there is no back-pressure: register writes and sleep requests take effect on the clock edge where they are sampled, or they are dropped.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, `reg_rdata` reads 8'h07, `mode_o` is 0 (active), `core_run` is 1, `clk_sel_sub` is 0 and `div_sel` is 2'b11.
- R2: The register layout is: bit 7 deep-stop enable, bits 6:4 wait code, bit 3 subclock enable, bits 1:0 divide code. A write with `reg_we` high in a running mode updates the register at the clock edge. Bit 2 always reads 1, whatever value is written to it.
- R3: The `mode_o` codes are 0 active, 1 subactive, 2 sleep, 3 subsleep, 4 standby, 5 watch and 6 settling. With bit 7 at 0, a sleep request in active mode enters sleep, and a sleep request in subactive mode enters subsleep.
- R4: With bit 7 at 1, a sleep request in active mode enters watch when `watch_sel` is 1, and standby when `watch_sel` is 0.
- R5: With bit 7 at 1, a sleep request in subactive mode enters watch, whatever the value of `watch_sel`.
- R6: Bit 3 at 1 makes the running mode subactive and drives `clk_sel_sub` to 1. Bit 3 at 0 makes it active and drives `clk_sel_sub` to 0.
- R7: `div_sel` equals bits 1:0. Codes 0, 1, 2 and 3 stand for the oscillator clock divided by 16, 32, 64 and 128.
- R8: A wake event in standby or watch moves to settling (code 6) on the next edge. Settling lasts exactly N cycles, where N is 8192, 16384, 1024, 2048, 4096, 2, 8 or 16 for wait codes 0 through 7. After that the controller returns to the running mode that bit 3 selects.
- R9: A wake event in sleep or subsleep returns to the running mode on the next clock edge, with no settling.
- R10: A register write in any non-running mode is dropped. A sleep request in any mode from 2 to 5 is ignored.
- R11: `core_run` is 1 exactly when `mode_o` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| sleep_req | input | 1 | One-cycle pulse from the core when the sleep instruction executes |
| wake_evt | input | 1 | Wake-up event |
| watch_sel | input | 1 | Selects watch (1) or standby (0) for a deep stop from active mode |
| mode_o | output | 3 | Current mode code |
| clk_sel_sub | output | 1 | 1 selects the subclock for the core |
| div_sel | output | 2 | Divide code for medium-speed active mode |
| core_run | output | 1 | Core run enable |

## Verification
The bench measures the length of every settling window across several wait codes, including the shortest (2 cycles) and a long one (16384 cycles). A counter that is off by one, or that misreads the code table, shows up as a settling window of the wrong length. It takes the deep-stop path from both active and subactive mode, with `watch_sel` at both levels. A design that lets `watch_sel` steer the subactive case, or that mixes up standby and watch, reports the wrong mode. While the core is stopped, the bench also tries register writes and repeated sleep requests. A design that accepts either one changes the register value or the mode that the bench reads back after wake-up.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    MODE_ACTIVE   = 3'd0,
    MODE_SUBACT   = 3'd1,
    MODE_SLEEP    = 3'd2,
    MODE_SUBSLEEP = 3'd3,
    MODE_STANDBY  = 3'd4,
    MODE_WATCH    = 3'd5,
    MODE_SETTLE   = 3'd6
  } lpm_mode_e;

  // settling length in clock states for each wait code
  function automatic logic [14:0] settle_len(input logic [2:0] code);
    logic [14:0] n;
    case (code)
      3'd0: n = 15'd8192;
      3'd1: n = 15'd16384;
      3'd2: n = 15'd1024;
      3'd3: n = 15'd2048;
      3'd4: n = 15'd4096;
      3'd5: n = 15'd2;
      3'd6: n = 15'd8;
      default: n = 15'd16;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/lpm_ctrl_reg.sv
module lpm_ctrl_reg #(
  parameter int          W        = 8,
  parameter logic [7:0]  RST_VAL  = 8'h07,
  parameter logic [7:0]  FIX_ONES = 8'h04
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         accept,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= RST_VAL;
    else if (we && accept)
      q <= wdata | FIX_ONES;
  end

  assign rdata = q;
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          en,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= len - 1'b1;
    else if (en && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic       watch_sel,
  input  logic       deep_en,
  input  logic       sub_en,
  input  logic       settle_done,
  output logic       settle_load,
  output logic       settling,
  output logic       running,
  output logic [2:0] mode
);
  lpm_mode_e st, st_nx;

  always_comb begin
    st_nx       = st;
    settle_load = 1'b0;
    case (st)
      MODE_ACTIVE: if (sleep_req) begin
        if (sub_en)
          st_nx = deep_en ? MODE_WATCH : MODE_SUBSLEEP;
        else if (deep_en)
          st_nx = watch_sel ? MODE_WATCH : MODE_STANDBY;
        else
          st_nx = MODE_SLEEP;
      end
      MODE_SLEEP, MODE_SUBSLEEP:
        if (wake_evt) st_nx = MODE_ACTIVE;
      MODE_STANDBY, MODE_WATCH:
        if (wake_evt) begin
          st_nx       = MODE_SETTLE;
          settle_load = 1'b1;
        end
      MODE_SETTLE:
        if (settle_done) st_nx = MODE_ACTIVE;
      default: st_nx = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= MODE_ACTIVE;
    else        st <= st_nx;
  end

  assign running  = (st == MODE_ACTIVE);
  assign settling = (st == MODE_SETTLE);
  assign mode     = (running && sub_en) ? MODE_SUBACT : st;
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sleep_req,
  input  logic             wake_evt,
  input  logic             watch_sel,
  output logic [2:0]       mode_o,
  output logic             clk_sel_sub,
  output logic [1:0]       div_sel,
  output logic             core_run
);
  localparam int DEEP_BIT = REG_W - 1;
  localparam int SUB_BIT  = 3;

  logic             running, settling, settle_load, settle_done;
  logic [REG_W-1:0] ctl;
  logic [CNT_W-1:0] wait_len;

  lpm_ctrl_reg #(.W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .accept(running),
    .wdata(reg_wdata), .rdata(ctl)
  );

  assign wait_len = CNT_W'(settle_len(ctl[6:4]));

  lpm_settle_timer #(.CW(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .en(settling),
    .len(wait_len), .done(settle_done)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .watch_sel(watch_sel), .deep_en(ctl[DEEP_BIT]), .sub_en(ctl[SUB_BIT]),
    .settle_done(settle_done), .settle_load(settle_load),
    .settling(settling), .running(running), .mode(mode_o)
  );

  assign reg_rdata   = ctl;
  assign clk_sel_sub = ctl[SUB_BIT];
  assign div_sel     = ctl[1:0];
  assign core_run    = running;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       sleep_req,
  input logic       wake_evt,
  input logic [2:0] mode_o,
  input logic       clk_sel_sub,
  input logic       core_run
);
  // R8
  settle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd6 && $past(mode_o) != 3'd6) |->
      ($past(wake_evt) && ($past(mode_o) == 3'd4 || $past(mode_o) == 3'd5)));

  // R9
  quick_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd2 || mode_o == 3'd3) && wake_evt) |=> (mode_o <= 3'd1));

  // R10
  frozen_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_run && reg_we) |=> $stable(reg_rdata));

  // R10
  ignore_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o >= 3'd2 && mode_o <= 3'd5 && sleep_req && !wake_evt) |=> $stable(mode_o));

  // R11
  run_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run == (mode_o <= 3'd1));

  // R6
  sub_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1) |-> clk_sel_sub);
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .sleep_req(sleep_req), .wake_evt(wake_evt), .mode_o(mode_o),
  .clk_sel_sub(clk_sel_sub), .core_run(core_run)
);

// File: tb/sim_lpm_sequencer.sv
module sim_lpm_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sleep_req = 1'b0;
  logic       wake_evt = 1'b0;
  logic       watch_sel = 1'b0;
  logic [2:0] mode_o;
  logic       clk_sel_sub;
  logic [1:0] div_sel;
  logic       core_run;

  int checks = 0;
  int errors = 0;
  int settle_seen = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  lpm_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .watch_sel(watch_sel), .mode_o(mode_o), .clk_sel_sub(clk_sel_sub),
    .div_sel(div_sel), .core_run(core_run)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic slp();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  // driver: push expected settle length, then raise wake
  task automatic wake(input int n);
    @(negedge clk); wake_evt = 1'b1;
    if (n > 0) exp_q.push_back(n);
    @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic wait_run();
    while (mode_o > 3'd1) @(negedge clk);
  endtask

  // monitor: measure each settling window and compare against queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (mode_o == 3'd6) begin
        settle_seen++;
        if (core_run) begin
          checks++; errors++;
          $display("FAIL R11 actual=1 expected=0 (core_run in settling)");
        end
      end else if (settle_seen > 0) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 actual=%0d expected=none", settle_seen);
        end else begin
          chk("R8 settle length", settle_seen, exp_q.pop_front());
        end
        settle_seen = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h07);
    chk("R1 mode", mode_o, 0);
    chk("R1 core_run", core_run, 1);
    chk("R1 clk_sel_sub", clk_sel_sub, 0);
    chk("R7 div reset", div_sel, 3);

    // R2 reserved bit reads 1
    wr(8'h00);
    chk("R2 rdata", reg_rdata, 8'h04);
    chk("R7 div 0", div_sel, 0);
    wr(8'h5A);
    chk("R2 rdata", reg_rdata, 8'h5E);
    chk("R6 subactive", mode_o, 1);
    chk("R6 clk_sel_sub", clk_sel_sub, 1);
    chk("R7 div 2", div_sel, 2);

    // R3 subsleep, R10 ignores, R9 quick wake
    slp();
    chk("R3 subsleep", mode_o, 3);
    chk("R11 run low", core_run, 0);
    slp();
    chk("R10 sleep ignored", mode_o, 3);
    wr(8'h00);
    wake(0);
    chk("R9 back to subactive", mode_o, 1);
    chk("R10 write dropped", reg_rdata, 8'h5E);

    wr(8'h01);
    chk("R6 active", mode_o, 0);
    chk("R6 main clock", clk_sel_sub, 0);
    slp();
    chk("R3 sleep", mode_o, 2);
    wake(0);
    chk("R9 back to active", mode_o, 0);

    // R4 standby from active, wait code 5 -> 2
    wr(8'hD0);
    watch_sel = 1'b0;
    slp();
    chk("R4 standby", mode_o, 4);
    wake(2);
    wait_run();
    chk("R8 return active", mode_o, 0);

    // R4 watch from active, wait code 6 -> 8
    wr(8'hE0);
    watch_sel = 1'b1;
    slp();
    chk("R4 watch", mode_o, 5);
    wake(8);
    wait_run();

    // R5 watch from subactive even with watch_sel low, code 7 -> 16
    wr(8'hF8);
    watch_sel = 1'b0;
    slp();
    chk("R5 watch from sub", mode_o, 5);
    wake(16);
    wait_run();
    chk("R8 return subactive", mode_o, 1);

    wr(8'hA0);
    slp();
    wake(1024);
    wait_run();
    wr(8'h80);
    slp();
    wake(8192);
    wait_run();
    wr(8'h90);
    slp();
    wake(16384);
    wait_run();
    chk("R8 final active", mode_o, 0);

    repeat (3) @(negedge clk);
    chk("R8 queue drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule